// File: doc/BRIEF.md
# Four-Level FSK Receiver Acquisition Sequencer

This block sits on the host side of a four-level FSK packet modem receiver. It programs the modem through a small register-write port that carries a control word (PLL bandwidth and level-measurement mode) and a command word (search task code plus two acquire flags). When it leaves reset it selects a wide PLL bandwidth and slow peak-detect level measurement. It then waits until carrier has been present without a break for a fixed number of symbol periods, which covers the delay through the receive filter. After that it starts a frame-sync search with both the clock-acquire flag and the level-acquire flag set.

When the modem interrupts to report that the search has ended, the sequencer narrows the PLL to medium bandwidth and treats the channel as locked. From then on, each host request for the next frame sends one more search task with both acquire flags cleared. If carrier is lost while the sequencer is waiting or locked, it restores wide bandwidth and goes back to qualifying carrier. The next burst therefore gets a full reacquisition. The same sequence serves a receiver that joins before the far transmitter starts and one that joins part-way through a run of back-to-back frames.

Top module: `fsk_acq_seq`

## Requirements
- R1: During and after reset, the port presents a control write (`wr_sel_o`=0) with data 0x04. The control word places PLL bandwidth in bits [1:0] (00 wide, 01 medium) and level mode in bits [3:2] (01 slow peak detect).
- R2: Once `wr_valid_o` is high, it stays high and `wr_sel_o`/`wr_data_o` stay unchanged until a cycle in which `wr_ready_i` is high. Each accepted word is presented only once, and the control word is accepted before any command word is presented.
- R3: The acquire command is presented in the cycle after the clock edge that samples the QUAL_SYMS-th (default 8) `sym_tick_i` pulse. Carrier must have been high throughout those pulses, and the command is never presented earlier.
- R4: Any cycle with `carrier_i` low during qualification resets the symbol count to zero.
- R5: The acquire command (`wr_sel_o`=1) carries task code in bits [3:0] (1 = frame-sync search, 2 = "H" search, chosen by USE_H_TASK), the clock-acquire flag in bit 4 and the level-acquire flag in bit 5, both set to 1. With the default configuration the data is 0x31.
- R6: An interrupt while waiting for the first search to end causes a control write of 0x04 | medium = 0x05. After it is accepted the sequencer is locked.
- R7: In the locked state a `next_frame_i` pulse causes a command write with both acquire flags 0. The default data is 0x01. Bandwidth stays medium and no control write occurs.
- R8: `next_frame_i` has no effect in any state other than locked, including while a tracking search is outstanding.
- R9: Loss of carrier while waiting for a search or while locked causes a control write of 0x04 (wide). A full qualification and an acquire command with both flags set follow.
- R10: Symbol ticks that occur before the initial control word is accepted do not count toward qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Carrier detect, high while carrier present |
| sym_tick_i | input | 1 | One-cycle strobe once per symbol period |
| modem_irq_i | input | 1 | Modem interrupt: search finished |
| next_frame_i | input | 1 | Host request to read the next frame |
| wr_ready_i | input | 1 | Modem register port accepts the word |
| wr_valid_o | output | 1 | Register write presented |
| wr_sel_o | output | 1 | 0 = control word, 1 = command word |
| wr_data_o | output | 8 | Register write data |

## Verification
The bench sweeps every carrier dropout position from one to seven qualified symbols. A counter that failed to clear on a dropout would issue the acquire command early. It stalls `wr_ready_i` for several lengths on every kind of write. A design that dropped or changed a word under backpressure would be flagged, and so would one that counted ticks while the first control word was still pending. It sends next-frame requests in every non-locked state and checks that no write follows. It also removes carrier both while locked and while a tracking search is outstanding. A design that kept medium bandwidth, or reacquired without the acquire flags, would present the wrong word.

// File: rtl/fsk_acq_seq_pkg.sv
package fsk_acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_INIT_CTL,
    ST_QUAL,
    ST_ACQ_CMD,
    ST_WAIT_SYNC,
    ST_MED_CTL,
    ST_LOCKED,
    ST_TRK_CMD,
    ST_WAIT_FRAME
  } seq_state_e;

  localparam logic [1:0] PLL_WIDE      = 2'b00;
  localparam logic [1:0] PLL_MEDIUM    = 2'b01;
  localparam logic [1:0] LEV_SLOW_PEAK = 2'b01;
  localparam logic [3:0] TASK_FSYNC    = 4'd1;
  localparam logic [3:0] TASK_FSYNC_H  = 4'd2;
  localparam logic       SEL_CTL       = 1'b0;
  localparam logic       SEL_CMD       = 1'b1;

  typedef struct packed {
    logic [3:0] rsvd;
    logic [1:0] lev_mode;
    logic [1:0] pll_bw;
  } ctl_word_t;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       acq_lev;
    logic       acq_clk;
    logic [3:0] task_code;
  } cmd_word_t;
endpackage

// File: rtl/fsk_acq_qual_cnt.sv
module fsk_acq_qual_cnt #(
  parameter int unsigned QUAL_SYMS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic carrier_i,
  input  logic sym_tick_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(QUAL_SYMS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_SYMS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && carrier_i && sym_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || !carrier_i) cnt_q <= '0;
    else if (done_o)             cnt_q <= '0;
    else if (sym_tick_i)         cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_i |=> cnt_q == '0);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/fsk_acq_word_fmt.sv
module fsk_acq_word_fmt
  import fsk_acq_seq_pkg::*;
#(
  parameter bit USE_H_TASK = 1'b0
) (
  input  seq_state_e state_i,
  output logic       valid_o,
  output logic       sel_o,
  output logic [7:0] data_o
);
  logic [3:0] task_code;
  ctl_word_t  ctl;
  cmd_word_t  cmd;

  generate
    if (USE_H_TASK) begin : g_task_h
      assign task_code = TASK_FSYNC_H;
    end else begin : g_task_plain
      assign task_code = TASK_FSYNC;
    end
  endgenerate

  always_comb begin
    ctl          = '0;
    cmd          = '0;
    ctl.lev_mode = LEV_SLOW_PEAK;
    ctl.pll_bw   = (state_i == ST_MED_CTL) ? PLL_MEDIUM : PLL_WIDE;
    cmd.task_code = task_code;
    cmd.acq_clk  = (state_i == ST_ACQ_CMD);
    cmd.acq_lev  = (state_i == ST_ACQ_CMD);
    valid_o      = 1'b0;
    sel_o        = SEL_CTL;
    data_o       = 8'(ctl);
    unique case (state_i)
      ST_INIT_CTL, ST_MED_CTL: valid_o = 1'b1;
      ST_ACQ_CMD, ST_TRK_CMD: begin
        valid_o = 1'b1;
        sel_o   = SEL_CMD;
        data_o  = 8'(cmd);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fsk_acq_seq.sv
module fsk_acq_seq
  import fsk_acq_seq_pkg::*;
#(
  parameter int unsigned QUAL_SYMS  = 8,
  parameter bit          USE_H_TASK = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       carrier_i,
  input  logic       sym_tick_i,
  input  logic       modem_irq_i,
  input  logic       next_frame_i,
  input  logic       wr_ready_i,
  output logic       wr_valid_o,
  output logic       wr_sel_o,
  output logic [7:0] wr_data_o
);
  seq_state_e state_q, state_d;
  logic       qual_done;
  logic       accept;

  fsk_acq_qual_cnt #(.QUAL_SYMS(QUAL_SYMS)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_QUAL),
    .carrier_i (carrier_i),
    .sym_tick_i(sym_tick_i),
    .done_o    (qual_done)
  );

  fsk_acq_word_fmt #(.USE_H_TASK(USE_H_TASK)) u_fmt (
    .state_i(state_q),
    .valid_o(wr_valid_o),
    .sel_o  (wr_sel_o),
    .data_o (wr_data_o)
  );

  assign accept = wr_valid_o && wr_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT_CTL:   if (accept) state_d = ST_QUAL;
      ST_QUAL:       if (qual_done) state_d = ST_ACQ_CMD;
      ST_ACQ_CMD:    if (accept) state_d = ST_WAIT_SYNC;
      ST_WAIT_SYNC:  if (!carrier_i) state_d = ST_INIT_CTL;
                     else if (modem_irq_i) state_d = ST_MED_CTL;
      ST_MED_CTL:    if (accept) state_d = ST_LOCKED;
      ST_LOCKED:     if (!carrier_i) state_d = ST_INIT_CTL;
                     else if (next_frame_i) state_d = ST_TRK_CMD;
      ST_TRK_CMD:    if (accept) state_d = ST_WAIT_FRAME;
      ST_WAIT_FRAME: if (!carrier_i) state_d = ST_INIT_CTL;
                     else if (modem_irq_i) state_d = ST_LOCKED;
      default:       state_d = ST_INIT_CTL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT_CTL;
    else         state_q <= state_d;
  end

  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_sel_o) && $stable(wr_data_o));

  // R3
  acq_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) && wr_sel_o && wr_data_o[5:4] == 2'b11 |-> $past(carrier_i && sym_tick_i));

  // R6
  irq_to_medium_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT_SYNC && carrier_i && modem_irq_i
      |=> wr_valid_o && !wr_sel_o && wr_data_o[1:0] == PLL_MEDIUM);

  // R7
  track_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOCKED && carrier_i && next_frame_i
      |=> wr_valid_o && wr_sel_o && wr_data_o[5:4] == 2'b00);

  // R9
  loss_to_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED || state_q == ST_WAIT_SYNC || state_q == ST_WAIT_FRAME) && !carrier_i
      |=> wr_valid_o && !wr_sel_o && wr_data_o[1:0] == PLL_WIDE);
endmodule

// File: tb/tb_fsk_acq_seq.sv
module tb_fsk_acq_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier = 1'b0, sym_tick = 1'b0, irq = 1'b0, next_frame = 1'b0, ready = 1'b0;
  logic       wr_valid, wr_sel;
  logic [7:0] wr_data;
  int         checks = 0, failures = 0, cyc = 0;
  bit         done = 1'b0;

  localparam logic [7:0] CTL_WIDE = 8'h04, CTL_MED = 8'h05, CMD_ACQ = 8'h31, CMD_TRK = 8'h01;

  fsk_acq_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .carrier_i(carrier), .sym_tick_i(sym_tick),
    .modem_irq_i(irq), .next_frame_i(next_frame), .wr_ready_i(ready),
    .wr_valid_o(wr_valid), .wr_sel_o(wr_sel), .wr_data_o(wr_data)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic sel, input logic [7:0] data, input string req, input int stall);
    chk(wr_valid && wr_sel == sel && wr_data == data, req, {wr_valid, wr_sel, wr_data}, {1'b1, sel, data});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(wr_valid && wr_sel == sel && wr_data == data, "R2", {wr_valid, wr_sel, wr_data}, {1'b1, sel, data});
    end
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic expect_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!wr_valid, req, {wr_valid, wr_sel, wr_data}, 10'h0);
    end
  endtask

  task automatic tick();
    sym_tick = 1'b1;
    @(negedge clk);
    sym_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic pulse_next();
    next_frame = 1'b1;
    @(negedge clk);
    next_frame = 1'b0;
  endtask

  // qualification: n-1 ticks with no write, then acquire command on n-th
  task automatic qualify(input string req);
    for (int i = 0; i < 7; i++) begin
      tick();
      chk(!wr_valid, req, {wr_valid, wr_sel, wr_data}, 10'h0);
    end
    sym_tick = 1'b1;
    @(negedge clk);
    sym_tick = 1'b0;
    chk(wr_valid && wr_sel && wr_data == CMD_ACQ, req, {wr_valid, wr_sel, wr_data}, {2'b11, CMD_ACQ});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_valid && !wr_sel && wr_data == CTL_WIDE, "R1", {wr_valid, wr_sel, wr_data}, {2'b10, CTL_WIDE});
    rst_n = 1'b1;
    @(negedge clk);
    // R10 ticks while initial control write stalls
    carrier = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(wr_valid && !wr_sel && wr_data == CTL_WIDE, "R10", {wr_valid, wr_sel, wr_data}, {2'b10, CTL_WIDE});
    end
    expect_wr(1'b0, CTL_WIDE, "R1", 2);
    chk(!wr_valid, "R2", {wr_valid, wr_sel, wr_data}, 10'h0);
    // R4 dropout sweep
    for (int k = 1; k < 8; k++) begin
      for (int j = 0; j < k; j++) tick();
      carrier = 1'b0;
      @(negedge clk);
      carrier = 1'b1;
      chk(!wr_valid, "R4", {wr_valid, wr_sel, wr_data}, 10'h0);
    end
    pulse_next();
    chk(!wr_valid, "R8", {wr_valid, wr_sel, wr_data}, 10'h0);
    qualify("R3");
    expect_wr(1'b1, CMD_ACQ, "R5", 3);
    // waiting for sync: next-frame ignored
    pulse_next();
    expect_idle("R8", 3);
    pulse_irq();
    expect_wr(1'b0, CTL_MED, "R6", 1);
    expect_idle("R7", 2);
    for (int f = 0; f < 3; f++) begin
      pulse_next();
      expect_wr(1'b1, CMD_TRK, "R7", f);
      pulse_next();
      expect_idle("R8", 2);
      pulse_irq();
      expect_idle("R7", 2);
    end
    // R9 carrier loss while locked
    carrier = 1'b0;
    @(negedge clk);
    expect_wr(1'b0, CTL_WIDE, "R9", 1);
    carrier = 1'b1;
    qualify("R9");
    expect_wr(1'b1, CMD_ACQ, "R9", 0);
    pulse_irq();
    expect_wr(1'b0, CTL_MED, "R6", 0);
    pulse_next();
    expect_wr(1'b1, CMD_TRK, "R7", 0);
    // R9 carrier loss with a tracking search outstanding
    carrier = 1'b0;
    @(negedge clk);
    expect_wr(1'b0, CTL_WIDE, "R9", 0);
    carrier = 1'b1;
    qualify("R9");
    expect_wr(1'b1, CMD_ACQ, "R5", 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule